// File: doc/BRIEF.md
# Write-Completion Status Poller

This block sits on the host side of a parallel nonvolatile memory. The host first loads a byte or page. Then it pulses `start_i` on the cycle after the write strobe edge that launches the memory's internal program cycle. The poller captures the last loaded address, the last written byte, a method select and a cycle limit. It then issues status reads to that address over a synchronous read port until it can tell that programming has finished. It ends every job with a one-cycle `done_o` or a one-cycle `err_o`.

Two detection methods are available:

- **Inversion method.** While the memory is programming, bit 7 of the status read comes back as the inverse of the written bit.
- **Alternation method.** While the memory is programming, bit 6 flips on every read.

A read that disagrees with completion is not taken as final. It is followed by two confirming reads. This prevents a false rejection when a read lands on the exact moment programming ends. A cycle-count limit stops a job that never completes.

Top module: `wr_done_poller`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, `busy_o`, `rd_req_o`, `done_o`, `err_o` and `timeout_o` are all 0.
- R2: A `start_i` sampled high while idle is accepted. On acceptance the block captures `wr_addr_i`, `wr_data_i`, `method_i` and `limit_i`, and clears `timeout_o`. In the next cycle `busy_o` is 1 and the first read strobe is issued.
- R3: Only one read is outstanding at a time. `rd_req_o` is high for a single cycle. The next strobe follows in the cycle after `rd_valid_i` returns data. `rd_addr_o` holds the captured address for the whole job.
- R4: With `method_i`=0 (inversion method), a poll read is a completion when its bit 7 equals bit 7 of the captured byte. With a one-cycle read latency, a job that ends after N reads raises `done_o` in cycle 2N+1 after the start edge.
- R5: With `method_i`=1 (alternation method), the first read of a job only records bit 6 and can never end the job. Each later poll read is a completion when its bit 6 equals bit 6 of the read just before it.
- R6: A poll read that is not a completion starts exactly two confirming reads. With the inversion method, both confirming reads are valid when the whole byte equals the captured byte. With the alternation method, they are valid when the second read's bit 6 equals the first's. If both are valid the job completes. Otherwise polling resumes, and the next poll read is compared with the second confirming read.
- R7: A counter is cleared on acceptance and advances on every busy cycle. At a clock edge where it equals the captured limit and no completion occurs, the job stops. `err_o` then pulses, and `timeout_o` goes high and stays high until the next accepted start.
- R8: When a completion and the limit fall on the same edge, the completion wins and `done_o` pulses instead of `err_o`.
- R9: A `start_i` pulse while busy is ignored. The running job keeps its address, method, byte and timing.
- R10: `done_o` and `err_o` are single-cycle pulses. They are never high together, and `busy_o` is 0 while either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| method_i | input | 1 | 0 = bit-7 inversion method, 1 = bit-6 alternation method |
| wr_addr_i | input | AW | Address of the last loaded byte |
| wr_data_i | input | DW | Last byte written |
| limit_i | input | TW | Cycle limit for the job |
| rd_req_o | output | 1 | One-cycle read strobe |
| rd_addr_o | output | AW | Read address, held during a job |
| rd_data_i | input | DW | Read data |
| rd_valid_i | input | 1 | Read data valid |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle failure pulse |
| timeout_o | output | 1 | Limit reached, held until the next start |

## Verification
The bench sweeps both methods over memories that stay busy for zero to seven reads, using several data bytes. It compares the number of reads and the done cycle against an arithmetic model.

- A poller that ends on the first alternation read stops one read too early when the memory is already idle.
- One that trusts a single mismatch, or skips a confirming read, gets the read counts wrong for memories that finish between reads.
- Cases where the limit and the completion fall on the same edge expose a reversed priority, because the design raises `err_o` instead of `done_o`.
- A start pulse with a different address and method, injected mid-job, exposes a poller that restarts: its strobes move off the held address and its completion cycle shifts.

// File: rtl/wcp_pkg.sv
package wcp_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_REF  = 2'd0,
    PH_POLL = 2'd1,
    PH_CNF1 = 2'd2,
    PH_CNF2 = 2'd3
  } phase_t;

  localparam logic METHOD_INVERT = 1'b0;
  localparam logic METHOD_TOGGLE = 1'b1;

endpackage

// File: rtl/wcp_status_eval.sv
module wcp_status_eval #(
  parameter int DW      = 8,
  parameter int INV_BIT = 7,
  parameter int TGL_BIT = 6
) (
  input  logic          method_i,
  input  logic [DW-1:0] exp_i,
  input  logic          prev_tgl_i,
  input  logic [DW-1:0] rdata_i,
  output logic          hit_o,
  output logic          match_o,
  output logic          tgl_o
);
  import wcp_pkg::*;

  // hit: per-read completion criterion of the selected method
  // match: whole byte equals the written byte (true data returned)
  always_comb begin
    tgl_o   = rdata_i[TGL_BIT];
    match_o = (rdata_i == exp_i);
    if (method_i == METHOD_TOGGLE) begin
      hit_o = (rdata_i[TGL_BIT] == prev_tgl_i);
    end else begin
      hit_o = (rdata_i[INV_BIT] == exp_i[INV_BIT]);
    end
  end

endmodule

// File: rtl/wcp_limit_timer.sv
module wcp_limit_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [TW-1:0] lim_i,
  output logic          expired_o
);
  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      lim_q <= lim_i;
    end else if (run_i && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = (cnt_q == lim_q);

endmodule

// File: rtl/wcp_sequencer.sv
module wcp_sequencer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          method_i,
  input  logic [DW-1:0] exp_i,
  input  logic          rd_valid_i,
  input  logic          hit_i,
  input  logic          match_i,
  input  logic          tgl_i,
  input  logic          expired_i,
  output logic          accept_o,
  output logic          run_o,
  output logic          method_o,
  output logic [DW-1:0] exp_o,
  output logic          prev_tgl_o,
  output logic          rd_req_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          timeout_o
);
  import wcp_pkg::*;

  seq_state_t st_q;
  phase_t     ph_q;
  phase_t     nxt_ph;
  logic       cnf_ok_q;
  logic       finish;

  assign accept_o = (st_q == SEQ_IDLE) && start_i;
  assign run_o    = (st_q != SEQ_IDLE);

  // Decide, for a returned read, whether the job ends and which phase follows
  always_comb begin
    finish = 1'b0;
    nxt_ph = ph_q;
    unique case (ph_q)
      PH_REF:  nxt_ph = PH_POLL;
      PH_POLL: begin
        finish = hit_i;
        nxt_ph = PH_CNF1;
      end
      PH_CNF1: nxt_ph = PH_CNF2;
      PH_CNF2: begin
        finish = cnf_ok_q &
                 ((method_o == METHOD_TOGGLE) ? hit_i : match_i);
        nxt_ph = PH_POLL;
      end
      default: nxt_ph = PH_POLL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= SEQ_IDLE;
      ph_q       <= PH_POLL;
      cnf_ok_q   <= 1'b0;
      method_o   <= METHOD_INVERT;
      exp_o      <= '0;
      prev_tgl_o <= 1'b0;
      rd_req_o   <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      timeout_o  <= 1'b0;
    end else begin
      rd_req_o <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      unique case (st_q)
        SEQ_IDLE: begin
          if (start_i) begin
            st_q      <= SEQ_REQ;
            rd_req_o  <= 1'b1;
            busy_o    <= 1'b1;
            timeout_o <= 1'b0;
            method_o  <= method_i;
            exp_o     <= exp_i;
            ph_q      <= (method_i == METHOD_TOGGLE) ? PH_REF : PH_POLL;
          end
        end
        SEQ_REQ: begin
          if (expired_i) begin
            st_q      <= SEQ_IDLE;
            busy_o    <= 1'b0;
            err_o     <= 1'b1;
            timeout_o <= 1'b1;
          end else begin
            st_q <= SEQ_WAIT;
          end
        end
        SEQ_WAIT: begin
          if (rd_valid_i) begin
            prev_tgl_o <= tgl_i;
            if (ph_q == PH_CNF1) begin
              cnf_ok_q <= (method_o == METHOD_TOGGLE) ? 1'b1 : match_i;
            end
            if (finish) begin
              st_q   <= SEQ_IDLE;
              busy_o <= 1'b0;
              done_o <= 1'b1;
            end else if (expired_i) begin
              st_q      <= SEQ_IDLE;
              busy_o    <= 1'b0;
              err_o     <= 1'b1;
              timeout_o <= 1'b1;
            end else begin
              st_q     <= SEQ_REQ;
              rd_req_o <= 1'b1;
              ph_q     <= nxt_ph;
            end
          end else if (expired_i) begin
            st_q      <= SEQ_IDLE;
            busy_o    <= 1'b0;
            err_o     <= 1'b1;
            timeout_o <= 1'b1;
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wr_done_poller.sv
module wr_done_poller #(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int TW      = 16,
  parameter int INV_BIT = 7,
  parameter int TGL_BIT = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          method_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [TW-1:0] limit_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  input  logic          rd_valid_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          timeout_o
);

  logic          accept;
  logic          run;
  logic          method_q;
  logic [DW-1:0] exp_q;
  logic          prev_tgl;
  logic          hit;
  logic          match;
  logic          tgl;
  logic          expired;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= wr_addr_i;
    end
  end

  assign rd_addr_o = addr_q;

  wcp_status_eval #(
    .DW     (DW),
    .INV_BIT(INV_BIT),
    .TGL_BIT(TGL_BIT)
  ) eval_i (
    .method_i  (method_q),
    .exp_i     (exp_q),
    .prev_tgl_i(prev_tgl),
    .rdata_i   (rd_data_i),
    .hit_o     (hit),
    .match_o   (match),
    .tgl_o     (tgl)
  );

  wcp_limit_timer #(
    .TW(TW)
  ) timer_i (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (accept),
    .run_i    (run),
    .lim_i    (limit_i),
    .expired_o(expired)
  );

  wcp_sequencer #(
    .DW(DW)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .method_i  (method_i),
    .exp_i     (wr_data_i),
    .rd_valid_i(rd_valid_i),
    .hit_i     (hit),
    .match_i   (match),
    .tgl_i     (tgl),
    .expired_i (expired),
    .accept_o  (accept),
    .run_o     (run),
    .method_o  (method_q),
    .exp_o     (exp_q),
    .prev_tgl_o(prev_tgl),
    .rd_req_o  (rd_req_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .timeout_o (timeout_o)
  );

endmodule

// File: rtl/wr_done_poller_chk.sv
module wr_done_poller_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          timeout_o
);

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o); // R2

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> busy_o); // R3

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |=> !rd_req_o); // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o)); // R3

  AST_ERR_SETS_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    err_o |-> timeout_o); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o); // R10

  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, err_o, rd_req_o})); // R10

  AST_END_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (done_o || err_o) |-> !busy_o); // R10

endmodule

bind wr_done_poller wr_done_poller_chk #(.AW(AW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .rd_req_o (rd_req_o),
  .rd_addr_o(rd_addr_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .timeout_o(timeout_o)
);

// File: tb/wr_done_poller_tb_top.sv
`timescale 1ns/1ps
module wr_done_poller_tb_top;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          method_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [TW-1:0] limit_i = '0;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] rd_data_i = '0;
  logic          rd_valid_i = 1'b0;
  logic          busy_o, done_o, err_o, timeout_o;

  int n_chk = 0;
  int n_fail = 0;

  // memory model configuration (set by tasks while idle)
  int            mdl_k = 0;
  logic          mdl_md = 1'b0;
  logic [DW-1:0] mdl_exp = '0;
  logic [AW-1:0] mdl_addr = '0;
  int            mdl_reads = 0;
  int            addr_bad = 0;

  always #4 clk = ~clk;

  wr_done_poller #(.AW(AW), .DW(DW), .TW(TW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .method_i(method_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .limit_i(limit_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .rd_valid_i(rd_valid_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .timeout_o(timeout_o)
  );

  // status byte for read k of a memory that stays busy for kb reads
  function automatic logic [DW-1:0] mdl_status(input int k, input int kb,
                                               input logic md, input logic [DW-1:0] e);
    logic [DW-1:0] v;
    v = e;
    if (k < kb) begin
      if (md) v[6] = (k % 2 == 0);
      else    v[7] = ~e[7];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (start_i && !busy_o) mdl_reads <= 0;
    else if (rd_req_o) mdl_reads <= mdl_reads + 1;
    rd_valid_i <= rd_req_o;
    if (rd_req_o) begin
      rd_data_i <= mdl_status(mdl_reads, mdl_k, mdl_md, mdl_exp);
      if (rd_addr_o !== mdl_addr) addr_bad <= addr_bad + 1;
    end
  end

  // reads needed, inversion method: poll, then two confirms on a mismatch
  function automatic int ref_inv(input int kb);
    for (int g = 0; g < 100000; g++) begin
      if (3 * g >= kb) return 3 * g + 1;
      if (3 * g + 1 >= kb) return 3 * g + 3;
    end
    return -1;
  endfunction

  function automatic logic sbit(input int k, input int kb, input logic e6);
    return (k < kb) ? (k % 2 == 0) : e6;
  endfunction

  // reads needed, alternation method: reference read, then poll/confirm
  function automatic int ref_tgl(input int kb, input logic e6);
    logic prev;
    int   k;
    prev = sbit(0, kb, e6);
    k = 1;
    for (int it = 0; it < 100000; it++) begin
      if (sbit(k, kb, e6) == prev) return k + 1;
      if (sbit(k + 2, kb, e6) == sbit(k + 1, kb, e6)) return k + 3;
      prev = sbit(k + 2, kb, e6);
      k += 3;
    end
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input logic md, input logic [7:0] ex, input int kb,
                          input int lim, input bit inj, input string req);
    int nrd, expc, cyc, bad0;
    bit want_err;
    logic [AW-1:0] ad;
    nrd      = md ? ref_tgl(kb, ex[6]) : ref_inv(kb);
    want_err = (lim < 2 * nrd - 1);
    expc     = want_err ? lim + 2 : 2 * nrd + 1;
    ad       = AW'(32'h1A5C3 + kb * 977 + int'(ex) + lim * 31);
    @(negedge clk);
    mdl_k = kb; mdl_md = md; mdl_exp = ex; mdl_addr = ad;
    method_i = md; wr_data_i = ex; wr_addr_i = ad; limit_i = TW'(lim);
    start_i = 1'b1;
    bad0 = addr_bad;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    chk(busy_o === 1'b1, "R2", "busy after start", int'(busy_o), 1);
    chk(timeout_o === 1'b0, "R7", "timeout cleared by start", int'(timeout_o), 0);
    while (!done_o && !err_o && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (inj && cyc == 3) begin
        start_i = 1'b1; method_i = ~md; wr_addr_i = ~ad;
        wr_data_i = ~ex; limit_i = '0;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    chk(err_o == want_err, req, "err outcome", int'(err_o), int'(want_err));
    chk(cyc == expc, req, "end cycle", cyc, expc);
    if (!want_err) chk(mdl_reads == nrd, req, "read count", mdl_reads, nrd);
    chk(addr_bad == bad0, "R3", "strobes off held address", addr_bad - bad0, 0);
    chk(timeout_o == want_err, "R7", "timeout level", int'(timeout_o), int'(want_err));
    @(negedge clk);
    chk(!done_o && !err_o, "R10", "end pulse width", int'(done_o | err_o), 0);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'hA5;
      3: return 8'h5A;
      4: return 8'h40;
      default: return 8'h80;
    endcase
  endfunction

  initial begin
    #(64'd200000 * 8);
    n_fail++;
    $display("FAIL watchdog (all R): actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk({busy_o, rd_req_o, done_o, err_o, timeout_o} == 5'b0, "R1", "outputs in reset",
        int'({busy_o, rd_req_o, done_o, err_o, timeout_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy_o, rd_req_o, done_o, err_o, timeout_o} == 5'b0, "R1", "outputs after reset",
        int'({busy_o, rd_req_o, done_o, err_o, timeout_o}), 0);

    // R4 R5 R6: both methods, busy lengths 0..7, several bytes
    for (int md = 0; md < 2; md++)
      for (int ei = 0; ei < 6; ei++)
        for (int kb = 0; kb < 8; kb++)
          run_case(md[0], pat(ei), kb, 3000, 1'b0, md ? "R5/R6" : "R4/R6");

    // R5: idle memory, first alternation read must not end the job
    run_case(1'b1, 8'h40, 0, 3000, 1'b0, "R5");
    run_case(1'b1, 8'h00, 0, 3000, 1'b0, "R5");

    // R7: never-finishing memory, limits 0..6
    for (int md = 0; md < 2; md++)
      for (int lim = 0; lim < 7; lim++)
        run_case(md[0], 8'h3C, 1000, lim, 1'b0, "R7");

    // R8: completion on the limit edge wins; one less gives timeout
    run_case(1'b0, 8'h81, 0, 1, 1'b0, "R8");
    run_case(1'b0, 8'h81, 0, 0, 1'b0, "R8");
    run_case(1'b1, 8'h40, 0, 3, 1'b0, "R8");
    run_case(1'b1, 8'h40, 0, 2, 1'b0, "R8");
    run_case(1'b0, 8'h11, 2, 7, 1'b0, "R8");

    // R9: start pulse mid-job is ignored
    run_case(1'b0, 8'hC3, 5, 3000, 1'b1, "R9");
    run_case(1'b1, 8'h24, 6, 3000, 1'b1, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule